// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the bus-facing half of a synchronous serial master. A host reaches six word-addressed registers over a simple single-cycle register bus. Two of them configure the serial engine: frame size, clock mode and divider in one, and enables and options in the other. One is the data port, one reports FIFO and engine status, one holds the clock prescaler, and one shows the raw interrupt causes. A write to the interrupt register clears the sticky overrun cause. Frames written by the host wait in an 8-entry transmit FIFO. Frames returned by the engine wait in an 8-entry receive FIFO.

A three-state link machine hands transmit frames to a separate bit-level serial engine through a valid/ready pair. In `LNK_IDLE` it waits until the enable bit is set and the transmit FIFO holds a frame, then moves to `LNK_OFFER`. `LNK_OFFER` presents the head frame. If the engine accepts it, the frame is popped and the machine moves to `LNK_SHIFT`. If the enable bit has dropped, the machine returns to `LNK_IDLE` without a pop. `LNK_SHIFT` waits for the engine to return a received frame, then goes back to `LNK_IDLE`.

Clearing the enable bit stops new frames from leaving but keeps both FIFOs intact. The engine itself applies the clock mode, the loopback bit and the master/slave bit; this block only passes them on.

Top module: `spi_fe_top`

## Requirements
- R1: After reset, CR0, CR1 and the prescaler read 0x0000. Status reads 0x0003. The raw interrupt register reads 0x0002. All interrupt outputs are low, `eng_tx_valid_o` is low and `bus_rdata_o` is 0.
- R2: The register words are decoded by word index. Index 0 is CR0 (16 bits). Index 1 is CR1 (7 bits; upper bits read 0). Index 2 is data. Index 3 is status. Index 4 is the prescaler (8 bits, bit 0 always reads 0). Index 5 is the raw interrupt register. Any other index reads 0. Read data appears on `bus_rdata_o` in the cycle after the access and holds until the next read.
- R3: `cfg_cr0_o`, `cfg_cr1_o` and `cfg_cpsr_o` show the stored register values from the cycle after a write. The CR0 fields are: data-size code (bits per word minus one) at 3:0, phase at 6, polarity at 7, rate divider at 15:8.
- R4: A write to the data index pushes the frame into the transmit FIFO. A write made while the FIFO holds 8 frames is dropped.
- R5: A read of the data index pops and returns the oldest receive frame. A read of an empty receive FIFO returns 0 and changes nothing.
- R6: Status bits are: bit 0 transmit FIFO empty, bit 1 transmit FIFO not full, bit 2 receive FIFO not empty, bit 3 receive FIFO full, bit 4 busy (link machine not in `LNK_IDLE`).
- R7: Frames are offered on `eng_tx_valid_o`/`eng_tx_frame_o` only while CR1 bit 4 (enable) is 1. They are offered in write order, one per trip through `LNK_IDLE`, `LNK_OFFER` and `LNK_SHIFT`. The machine leaves `LNK_SHIFT` only on `eng_rx_valid_i`.
- R8: Clearing the enable bit stops further offers without a pop. The transmit and receive FIFO contents are kept.
- R9: A frame on `eng_rx_valid_i`/`eng_rx_frame_i` is pushed into the receive FIFO when the FIFO is not full.
- R10: A frame that arrives while the receive FIFO is full is discarded and sets the sticky overrun bit (interrupt register bit 2). Any write to index 5 clears the bit. A new overrun in the same cycle as the clear wins.
- R11: Raw interrupt bit 0 is 1 while the receive FIFO holds 4 or more frames. Raw interrupt bit 1 is 1 while the transmit FIFO holds 4 or fewer frames.
- R12: `irq_rx_o`, `irq_tx_o` and `irq_ror_o` are raw bits 0, 1 and 2 gated by CR1 bits 0, 1 and 2. `irq_any_o` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, registered |
| eng_tx_valid_o | output | 1 | Frame offered to the serial engine |
| eng_tx_frame_o | output | 16 | Offered frame |
| eng_tx_ready_i | input | 1 | Engine takes the offered frame |
| eng_rx_valid_i | input | 1 | Engine returns a received frame |
| eng_rx_frame_i | input | 16 | Received frame |
| cfg_cr0_o | output | 16 | Frame size, clock mode, rate divider |
| cfg_cr1_o | output | 7 | Interrupt enables, loopback, enable, master/slave, output disable |
| cfg_cpsr_o | output | 8 | Clock prescaler (even) |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_ror_o | output | 1 | Receive overrun interrupt |
| irq_any_o | output | 1 | OR of the three interrupts |

## Verification
Read data is registered, so the bench drives each access for one cycle and samples `bus_rdata_o` at the falling edge after the capturing edge. Status, interrupt outputs and configuration outputs follow register state combinationally, so they reflect a write or FIFO change from the first falling edge after the updating edge. The link machine enters `LNK_OFFER` one edge after the enable and a frame are both present, and it pops on the edge where ready is high. The bench raises ready only after it sees valid, and returns a frame one cycle later. It checks the busy bit while the machine waits in `LNK_SHIFT`.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,
        LNK_OFFER = 2'd1,
        LNK_SHIFT = 2'd2
    } link_state_e;

    localparam int CR0_W  = 16;
    localparam int CR1_W  = 7;
    localparam int CPSR_W = 8;

    // register word indices
    localparam int WI_CR0  = 0;
    localparam int WI_CR1  = 1;
    localparam int WI_DATA = 2;
    localparam int WI_STAT = 3;
    localparam int WI_CPSR = 4;
    localparam int WI_INTR = 5;

    // CR1 bit positions
    localparam int C1_RXIE = 0;
    localparam int C1_TXIE = 1;
    localparam int C1_ORIE = 2;
    localparam int C1_EN   = 4;

endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    output logic [W-1:0]  dout_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    // DEPTH must be a power of two so the pointers wrap naturally
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_q;
    logic          push_ok, pop_ok;

    assign full_o  = (count_q == CW'(DEPTH));
    assign empty_o = (count_q == '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign dout_o  = mem[rd_ptr];
    assign count_o = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din_i;
    end

    // R4
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R4
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> full_o);

endmodule

// File: rtl/spi_fe_link.sv
module spi_fe_link
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tx_empty_i,
    input  logic tx_ready_i,
    input  logic rx_valid_i,
    output logic tx_valid_o,
    output logic tx_pop_o,
    output logic busy_o
);
    link_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE:  if (en_i && !tx_empty_i) state_d = LNK_OFFER;
            LNK_OFFER: begin
                if (!en_i)           state_d = LNK_IDLE;
                else if (tx_ready_i) state_d = LNK_SHIFT;
            end
            LNK_SHIFT: if (rx_valid_i) state_d = LNK_IDLE;
            default:   state_d = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_valid_o = 1'b0;
        tx_pop_o   = 1'b0;
        busy_o     = 1'b1;
        unique case (state_q)
            LNK_IDLE:  busy_o = 1'b0;
            LNK_OFFER: begin
                tx_valid_o = en_i;
                tx_pop_o   = en_i && tx_ready_i;
            end
            LNK_SHIFT: ;
            default:   busy_o = 1'b0;
        endcase
    end

    // R7
    link_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_SHIFT && !rx_valid_i) |=> state_q == LNK_SHIFT);

endmodule

// File: rtl/spi_fe_irq.sv
module spi_fe_irq #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic [CW-1:0] rx_count_i,
    input  logic [CW-1:0] tx_count_i,
    input  logic          ror_i,
    input  logic [2:0]    en_i,
    output logic [2:0]    raw_o,
    output logic          irq_rx_o,
    output logic          irq_tx_o,
    output logic          irq_ror_o,
    output logic          irq_any_o
);
    assign raw_o[0]  = (rx_count_i >= CW'(HALF));
    assign raw_o[1]  = (tx_count_i <= CW'(HALF));
    assign raw_o[2]  = ror_i;
    assign irq_rx_o  = raw_o[0] & en_i[0];
    assign irq_tx_o  = raw_o[1] & en_i[1];
    assign irq_ror_o = raw_o[2] & en_i[2];
    assign irq_any_o = irq_rx_o | irq_tx_o | irq_ror_o;
endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
    import spi_fe_pkg::*;
#(
    parameter int FW    = 16,
    parameter int DEPTH = 8,
    parameter int AW    = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic [FW-1:0]     bus_wdata_i,
    output logic [FW-1:0]     bus_rdata_o,
    output logic              eng_tx_valid_o,
    output logic [FW-1:0]     eng_tx_frame_o,
    input  logic              eng_tx_ready_i,
    input  logic              eng_rx_valid_i,
    input  logic [FW-1:0]     eng_rx_frame_i,
    output logic [CR0_W-1:0]  cfg_cr0_o,
    output logic [CR1_W-1:0]  cfg_cr1_o,
    output logic [CPSR_W-1:0] cfg_cpsr_o,
    output logic              irq_rx_o,
    output logic              irq_tx_o,
    output logic              irq_ror_o,
    output logic              irq_any_o
);
    logic [CR0_W-1:0]  cr0_q;
    logic [CR1_W-1:0]  cr1_q;
    logic [CPSR_W-1:0] cpsr_q;
    logic              ror_q;

    logic wr_acc, rd_acc, tx_push, rx_pop, ror_clr, ror_set;
    logic tx_pop, tx_full, tx_empty, rx_full, rx_empty, busy;
    logic [FW-1:0] rx_head, rd_mux;
    logic [CW-1:0] tx_count, rx_count;
    logic [2:0]    raw;
    logic [4:0]    status;

    assign wr_acc  = bus_sel_i && bus_wr_i;
    assign rd_acc  = bus_sel_i && !bus_wr_i;
    assign tx_push = wr_acc && (bus_addr_i == AW'(WI_DATA));
    assign rx_pop  = rd_acc && (bus_addr_i == AW'(WI_DATA));
    assign ror_clr = wr_acc && (bus_addr_i == AW'(WI_INTR));
    assign ror_set = eng_rx_valid_i && rx_full;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr0_q  <= '0;
            cr1_q  <= '0;
            cpsr_q <= '0;
        end else if (wr_acc) begin
            if (bus_addr_i == AW'(WI_CR0))  cr0_q  <= bus_wdata_i[CR0_W-1:0];
            if (bus_addr_i == AW'(WI_CR1))  cr1_q  <= bus_wdata_i[CR1_W-1:0];
            if (bus_addr_i == AW'(WI_CPSR)) cpsr_q <= {bus_wdata_i[CPSR_W-1:1], 1'b0};
        end
    end

    // sticky overrun: a new overrun beats a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ror_q <= 1'b0;
        else if (ror_set) ror_q <= 1'b1;
        else if (ror_clr) ror_q <= 1'b0;
    end

    spi_fe_fifo #(.W(FW), .DEPTH(DEPTH)) tx_fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (tx_push),
        .din_i   (bus_wdata_i),
        .pop_i   (tx_pop),
        .dout_o  (eng_tx_frame_o),
        .count_o (tx_count),
        .full_o  (tx_full),
        .empty_o (tx_empty)
    );

    spi_fe_fifo #(.W(FW), .DEPTH(DEPTH)) rx_fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (eng_rx_valid_i),
        .din_i   (eng_rx_frame_i),
        .pop_i   (rx_pop),
        .dout_o  (rx_head),
        .count_o (rx_count),
        .full_o  (rx_full),
        .empty_o (rx_empty)
    );

    spi_fe_link link_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cr1_q[C1_EN]),
        .tx_empty_i (tx_empty),
        .tx_ready_i (eng_tx_ready_i),
        .rx_valid_i (eng_rx_valid_i),
        .tx_valid_o (eng_tx_valid_o),
        .tx_pop_o   (tx_pop),
        .busy_o     (busy)
    );

    spi_fe_irq #(.DEPTH(DEPTH)) irq_i (
        .rx_count_i (rx_count),
        .tx_count_i (tx_count),
        .ror_i      (ror_q),
        .en_i       (cr1_q[C1_ORIE:C1_RXIE]),
        .raw_o      (raw),
        .irq_rx_o   (irq_rx_o),
        .irq_tx_o   (irq_tx_o),
        .irq_ror_o  (irq_ror_o),
        .irq_any_o  (irq_any_o)
    );

    assign status = {busy, rx_full, !rx_empty, !tx_full, tx_empty};

    always_comb begin
        rd_mux = '0;
        case (bus_addr_i)
            AW'(WI_CR0):  rd_mux = FW'(cr0_q);
            AW'(WI_CR1):  rd_mux = FW'(cr1_q);
            AW'(WI_DATA): rd_mux = rx_empty ? '0 : rx_head;
            AW'(WI_STAT): rd_mux = FW'(status);
            AW'(WI_CPSR): rd_mux = FW'(cpsr_q);
            AW'(WI_INTR): rd_mux = FW'(raw);
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata_o <= '0;
        else if (rd_acc) bus_rdata_o <= rd_mux;
    end

    assign cfg_cr0_o  = cr0_q;
    assign cfg_cr1_o  = cr1_q;
    assign cfg_cpsr_o = cpsr_q;

    // R7
    offer_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid_o |-> !tx_empty);

    // R8
    disabled_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cr1_q[C1_EN] |=> tx_count >= $past(tx_count));

    // R10
    ror_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ror_q) |-> $past(eng_rx_valid_i));

    // R10
    ror_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ror_q && !ror_clr) |=> ror_q);

endmodule

// File: tb/spi_fe_top_tb_top.sv
module spi_fe_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0;
    logic [15:0] tx_frame, rx_frame = '0;
    logic [15:0] cr0;
    logic [6:0]  cr1;
    logic [7:0]  cpsr;
    logic        irq_rx, irq_tx, irq_ror, irq_any;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fe_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .eng_tx_valid_o(tx_valid), .eng_tx_frame_o(tx_frame),
        .eng_tx_ready_i(tx_ready), .eng_rx_valid_i(rx_valid),
        .eng_rx_frame_i(rx_frame),
        .cfg_cr0_o(cr0), .cfg_cr1_o(cr1), .cfg_cpsr_o(cpsr),
        .irq_rx_o(irq_rx), .irq_tx_o(irq_tx), .irq_ror_o(irq_ror),
        .irq_any_o(irq_any)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // wait for an offer, accept it, check busy in the shift state, return ~frame
    task automatic serve(input logic [15:0] exp, input string tag);
        logic [15:0] st;
        while (!tx_valid) @(negedge clk);
        check(tag, tx_frame, exp);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        bus_read(4'd3, st);
        check("R6 busy in shift", {15'd0, st[4]}, 16'd1);
        rx_valid = 1'b1; rx_frame = ~exp;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 rdata", bus_rdata, 16'h0);
        check("R1 irq", {12'd0, irq_rx, irq_tx, irq_ror, irq_any}, 16'h0);
        check("R1 txvalid", {15'd0, tx_valid}, 16'h0);
        bus_read(4'd0, v); check("R1 cr0", v, 16'h0);
        bus_read(4'd1, v); check("R1 cr1", v, 16'h0);
        bus_read(4'd4, v); check("R1 cpsr", v, 16'h0);
        bus_read(4'd3, v); check("R1 status", v, 16'h0003);
        bus_read(4'd5, v); check("R1 intr", v, 16'h0002);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        bus_write(4'd0, 16'hA5C7);
        check("R3 cfg cr0", cr0, 16'hA5C7);
        bus_read(4'd0, v); check("R2 cr0", v, 16'hA5C7);
        bus_write(4'd1, 16'hFFEB);
        check("R3 cfg cr1", {9'd0, cr1}, 16'h006B);
        bus_read(4'd1, v); check("R2 cr1", v, 16'h006B);
        bus_write(4'd1, 16'h0000);
        bus_write(4'd4, 16'h0037);
        check("R3 cfg cpsr", {8'd0, cpsr}, 16'h0036);
        bus_read(4'd4, v); check("R2 cpsr even", v, 16'h0036);
        bus_read(4'd9, v); check("R2 unmapped", v, 16'h0);
        repeat (2) @(negedge clk);
        check("R2 rdata held", bus_rdata, 16'h0);
    endtask

    task automatic t_stream;
        logic [15:0] v;
        for (int i = 0; i < 9; i++) bus_write(4'd2, 16'h1000 + 16'(i));
        repeat (3) @(negedge clk);
        check("R7 no offer when disabled", {15'd0, tx_valid}, 16'h0);
        bus_read(4'd3, v); check("R4 R6 tx full status", v, 16'h0000);
        bus_read(4'd5, v); check("R11 intr tx full", v, 16'h0000);
        bus_write(4'd1, 16'h0010);
        for (int i = 0; i < 8; i++) serve(16'h1000 + 16'(i), "R7 frame order");
        repeat (3) @(negedge clk);
        check("R4 ninth write dropped", {15'd0, tx_valid}, 16'h0);
        bus_read(4'd3, v); check("R9 R6 rx full status", v, 16'h000F);
        bus_read(4'd5, v); check("R11 intr half marks", v, 16'h0003);
        check("R12 masked", {15'd0, irq_any}, 16'h0);
        bus_write(4'd1, 16'h0017);
        check("R12 rx tx irq", {12'd0, irq_rx, irq_tx, irq_ror, irq_any}, 16'h000D);
        rx_valid = 1'b1; rx_frame = 16'h1234;
        @(negedge clk);
        rx_valid = 1'b0;
        bus_read(4'd5, v); check("R10 overrun set", v, 16'h0007);
        check("R12 ror irq", {15'd0, irq_ror}, 16'h1);
        repeat (2) @(negedge clk);
        check("R10 overrun sticky", {15'd0, irq_ror}, 16'h1);
        bus_write(4'd5, 16'h0000);
        check("R10 overrun cleared", {15'd0, irq_ror}, 16'h0);
        bus_write(4'd1, 16'h0010);
        for (int i = 0; i < 8; i++) begin
            bus_read(4'd2, v);
            check("R5 R9 rx order", v, ~(16'h1000 + 16'(i)));
        end
        bus_read(4'd2, v); check("R5 R10 empty read zero", v, 16'h0);
        bus_read(4'd3, v); check("R5 status after drain", v, 16'h0003);
    endtask

    task automatic t_disable;
        logic [15:0] v;
        bus_write(4'd1, 16'h0000);
        bus_write(4'd2, 16'hBEE1);
        bus_write(4'd2, 16'hBEE2);
        bus_write(4'd1, 16'h0010);
        serve(16'hBEE1, "R7 first after enable");
        bus_write(4'd1, 16'h0000);
        repeat (4) @(negedge clk);
        check("R8 no offer after disable", {15'd0, tx_valid}, 16'h0);
        bus_read(4'd3, v); check("R8 fifos kept", v, 16'h0006);
        bus_write(4'd1, 16'h0010);
        serve(16'hBEE2, "R8 resume frame");
        bus_read(4'd2, v); check("R8 rx kept", v, ~16'hBEE1);
        bus_read(4'd2, v); check("R9 rx second", v, ~16'hBEE2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_stream();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule